// File: doc/BRIEF.md
# Remote Host Core Control Register

This block is the control register through which a remote host starts, stops and single-steps an embedded processor core. It also chooses which memory space a host memory access reaches. The host reaches the register through a read/write port. A register cycle is qualified by a command input and an access-enable input, and a lockout input can block it. When the command input is low, the same port carries host memory accesses. These accesses go to the space named by the two select bits of the register.

A small sequencer turns the start and single-step bits into a run enable for the core. Stopping is deferred until the core reports that its current instruction is complete. Host accesses to instruction memory or to either program-counter byte are granted only while the core is idle. Denied accesses are dropped and flagged. Host and core requests for data memory go through an arbiter. The core wins the first contested cycle, the two sides alternate on later contested cycles, and a lock input freezes the most recent winner. Holding remote read and remote write during reset, with access-enable low, brings the core out of reset already running.

Top module: `host_core_ctl`

## Requirements
- R1: A register write or read takes effect only in a cycle with `host_cmd`=1, `host_ae`=1 and `host_lockout`=0. In any other cycle the stored fields and `host_rdata` keep their values.
- R2: Bit layout, MSB first: 7 interrupt status, 6 single-step, 5 fast write, 4 latched read, 3 latched write, 2 start, 1:0 memory select. Bit 7 reads back as `irq_line`. Writing 1 to bit 7 pulses `irq_ack` for one cycle. `cfg_fast_wr`, `cfg_latch_rd`, `cfg_latch_wr` and `cfg_msel` show bits 5, 4, 3 and 1:0 from the cycle after the write. A read returns the fields in `host_rdata` after the read edge.
- R3: A synchronous reset clears every stored field. `core_go` is then 0 and `core_idle` is 1.
- R4: Writing start=1 while the core is idle raises `core_go` at the second clock edge after the write edge.
- R5: After start is cleared, `core_go` stays high until an edge that samples `core_insn_done`=1 with start still low. Only then does it fall.
- R6: Writing bit 6 = 1 and bit 2 = 0 while the core is idle and start is 0 runs exactly one instruction. `core_go` rises at the second edge, falls at the edge that samples `core_insn_done`, and bit 6 then reads 0. A step write made while start is 1 or while the core is busy leaves bit 6 at 0.
- R7: A host memory access (`host_cmd`=0, `host_ae`=1, `host_rd` or `host_wr`) while `core_idle`=1 with select code 01 (instruction), 10 (PC low) or 11 (PC high) raises only bit k of `host_tgt_gnt` for one cycle after the edge, where k is the code.
- R8: The same access with code 01, 10 or 11 while the core is not idle grants nothing. It pulses `acc_err` for one cycle instead.
- R9: With select code 00, a host access requests data memory. Uncontested requests are granted to the requester the cycle after the edge. The first of a run of contested cycles goes to the core, and later contested cycles alternate. The two grants are never high together.
- R10: While `dm_lock` is 1, a contested cycle that follows a contested cycle goes to the same side as the previous one.
- R11: Sampling `rst`=1 with `host_rd`=1, `host_wr`=1 and `host_ae`=0 leaves start=1 and `core_go`=1 directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cmd | input | 1 | 1 selects the register, 0 selects memory access |
| host_ae | input | 1 | Host access enable |
| host_lockout | input | 1 | Blocks register access when 1 |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Registered register read data |
| irq_line | input | 1 | Interrupt line state shown at bit 7 |
| irq_ack | output | 1 | One-cycle pulse on a write of 1 to bit 7 |
| core_insn_done | input | 1 | Core finished an instruction this cycle |
| core_dreq | input | 1 | Core requests data memory |
| dm_lock | input | 1 | Freezes the data-memory winner |
| core_go | output | 1 | Core may execute |
| core_idle | output | 1 | Core halted |
| cfg_fast_wr | output | 1 | Fast write mode |
| cfg_latch_rd | output | 1 | Latched read mode |
| cfg_latch_wr | output | 1 | Latched write mode |
| cfg_msel | output | 2 | Memory select code |
| host_dm_gnt | output | 1 | Data memory granted to host |
| core_dm_gnt | output | 1 | Data memory granted to core |
| host_tgt_gnt | output | 3 | Grants for codes 1..3 (bit k = code k) |
| acc_err | output | 1 | Denied access pulse |

## Verification
The hardest situations to reach are those that depend on history rather than on the current inputs. One is a stop request that lands while an instruction is still in flight. Another is a lock raised after the host has already won a contested cycle. The bench builds each history on purpose. It holds `core_insn_done` low for several cycles after clearing start, and again holds it high through the clearing write. It runs unlocked contested cycles until the host has won, and only then raises the lock. Every grant sequence is predicted from the parity of the contested-cycle index.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  localparam int CFG_W  = 8;
  localparam int TGT_N  = 4;
  localparam int MS_W   = $clog2(TGT_N);

  localparam int B_IRQ   = 7;
  localparam int B_STEP  = 6;
  localparam int B_FW    = 5;
  localparam int B_LR    = 4;
  localparam int B_LW    = 3;
  localparam int B_START = 2;

  localparam logic [MS_W-1:0] MS_DATA = '0;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2,
    SQ_STEP  = 2'd3
  } seq_t;

  typedef struct packed {
    logic            step;
    logic            fw;
    logic            lr;
    logic            lw;
    logic            start;
    logic [MS_W-1:0] ms;
  } cfg_t;
endpackage

// File: rtl/hcc_cfg_reg.sv
module hcc_cfg_reg
  import hcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_run,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             irq_line,
  input  logic             seq_idle,
  input  logic             step_done,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             irq_ack
);
  logic step_set;

  // a step is accepted only from a halted core with start held low
  assign step_set = wr_en && wdata[B_STEP] && !wdata[B_START]
                    && seq_idle && !cfg.start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      cfg.start <= boot_run;
      rdata     <= '0;
      irq_ack   <= 1'b0;
    end else begin
      irq_ack <= wr_en && wdata[B_IRQ];
      if (wr_en) begin
        cfg.fw    <= wdata[B_FW];
        cfg.lr    <= wdata[B_LR];
        cfg.lw    <= wdata[B_LW];
        cfg.start <= wdata[B_START];
        cfg.ms    <= wdata[MS_W-1:0];
      end
      if (step_set)       cfg.step <= 1'b1;
      else if (step_done) cfg.step <= 1'b0;
      if (rd_en)
        rdata <= {irq_line, cfg.step, cfg.fw, cfg.lr, cfg.lw, cfg.start, cfg.ms};
    end
  end
endmodule

// File: rtl/hcc_seq.sv
module hcc_seq
  import hcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic boot_run,
  input  logic start,
  input  logic step,
  input  logic insn_done,
  output logic core_go,
  output logic core_idle,
  output logic step_done
);
  seq_t st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      SQ_IDLE:  if (step) st_nx = SQ_STEP;
                else if (start) st_nx = SQ_RUN;
      SQ_RUN:   if (!start) st_nx = insn_done ? SQ_IDLE : SQ_DRAIN;
      SQ_DRAIN: if (start) st_nx = SQ_RUN;
                else if (insn_done) st_nx = SQ_IDLE;
      SQ_STEP:  if (insn_done) st_nx = SQ_IDLE;
      default:  st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= boot_run ? SQ_RUN : SQ_IDLE;
    else     st <= st_nx;
  end

  assign core_go   = (st != SQ_IDLE);
  assign core_idle = (st == SQ_IDLE);
  assign step_done = (st == SQ_STEP) && insn_done;
endmodule

// File: rtl/hcc_acc_dec.sv
module hcc_acc_dec
  import hcc_pkg::*;
#(
  parameter int N_TGT = TGT_N,
  localparam int SW   = $clog2(N_TGT)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [SW-1:0]    ms,
  input  logic             idle,
  output logic             host_dreq,
  output logic [N_TGT-1:1] tgt_gnt,
  output logic             acc_err
);
  logic [N_TGT-1:1] hit;

  for (genvar k = 1; k < N_TGT; k++) begin : g_tgt
    assign hit[k] = acc && (ms == SW'(k)) && idle;
  end

  assign host_dreq = acc && (ms == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_gnt <= '0;
      acc_err <= 1'b0;
    end else begin
      tgt_gnt <= hit;
      acc_err <= acc && (ms != '0) && !idle;
    end
  end
endmodule

// File: rtl/hcc_dm_arb.sv
module hcc_dm_arb (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic core_req,
  input  logic lock,
  output logic host_gnt,
  output logic core_gnt
);
  logic last_host, prev_cont, cont, win_host, host_take;

  assign cont = host_req && core_req;

  always_comb begin
    if (!prev_cont) win_host = 1'b0;
    else if (lock)  win_host = last_host;
    else            win_host = !last_host;
  end

  assign host_take = host_req && (!core_req || win_host);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_gnt  <= 1'b0;
      core_gnt  <= 1'b0;
      last_host <= 1'b0;
      prev_cont <= 1'b0;
    end else begin
      host_gnt  <= host_take;
      core_gnt  <= core_req && !host_take;
      prev_cont <= cont;
      if (host_req || core_req) last_host <= host_take;
    end
  end
endmodule

// File: rtl/host_core_ctl.sv
module host_core_ctl
  import hcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             host_cmd,
  input  logic             host_ae,
  input  logic             host_lockout,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [CFG_W-1:0] host_wdata,
  output logic [CFG_W-1:0] host_rdata,
  input  logic             irq_line,
  output logic             irq_ack,
  input  logic             core_insn_done,
  input  logic             core_dreq,
  input  logic             dm_lock,
  output logic             core_go,
  output logic             core_idle,
  output logic             cfg_fast_wr,
  output logic             cfg_latch_rd,
  output logic             cfg_latch_wr,
  output logic [MS_W-1:0]  cfg_msel,
  output logic             host_dm_gnt,
  output logic             core_dm_gnt,
  output logic [TGT_N-1:1] host_tgt_gnt,
  output logic             acc_err
);
  cfg_t cfg_q;
  logic boot_run, reg_ok, reg_wr, reg_rd, mem_acc;
  logic run_req, step_req, step_done, host_dreq;

  assign boot_run = rst && host_rd && host_wr && !host_ae;
  assign reg_ok   = host_cmd && host_ae && !host_lockout;
  assign reg_wr   = reg_ok && host_wr;
  assign reg_rd   = reg_ok && host_rd;
  assign mem_acc  = !host_cmd && host_ae && (host_rd || host_wr);

  hcc_cfg_reg u_reg (
    .clk(clk), .rst(rst), .boot_run(boot_run),
    .wr_en(reg_wr), .rd_en(reg_rd), .wdata(host_wdata),
    .irq_line(irq_line), .seq_idle(core_idle), .step_done(step_done),
    .cfg(cfg_q), .rdata(host_rdata), .irq_ack(irq_ack)
  );

  assign run_req  = cfg_q.start;
  assign step_req = cfg_q.step;

  hcc_seq u_seq (
    .clk(clk), .rst(rst), .boot_run(boot_run),
    .start(run_req), .step(step_req), .insn_done(core_insn_done),
    .core_go(core_go), .core_idle(core_idle), .step_done(step_done)
  );

  hcc_acc_dec #(.N_TGT(TGT_N)) u_dec (
    .clk(clk), .rst(rst), .acc(mem_acc), .ms(cfg_q.ms), .idle(core_idle),
    .host_dreq(host_dreq), .tgt_gnt(host_tgt_gnt), .acc_err(acc_err)
  );

  hcc_dm_arb u_arb (
    .clk(clk), .rst(rst), .host_req(host_dreq), .core_req(core_dreq),
    .lock(dm_lock), .host_gnt(host_dm_gnt), .core_gnt(core_dm_gnt)
  );

  assign cfg_fast_wr  = cfg_q.fw;
  assign cfg_latch_rd = cfg_q.lr;
  assign cfg_latch_wr = cfg_q.lw;
  assign cfg_msel     = cfg_q.ms;
endmodule

// File: rtl/hcc_chk.sv
module hcc_chk (
  input logic       clk,
  input logic       rst,
  input logic       core_go,
  input logic       core_idle,
  input logic       run_req,
  input logic       step_req,
  input logic       step_done,
  input logic       insn_done,
  input logic       host_dreq,
  input logic       core_dreq,
  input logic       dm_lock,
  input logic       host_dm_gnt,
  input logic       core_dm_gnt,
  input logic [3:1] tgt_gnt,
  input logic       acc_err
);
  logic cont;
  assign cont = host_dreq && core_dreq;

  p_gnt_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(host_dm_gnt && core_dm_gnt));

  p_core_first_r9: assert property (@(posedge clk) disable iff (rst)
    (cont && !$past(cont)) |=> core_dm_gnt);

  p_alternate_r9: assert property (@(posedge clk) disable iff (rst)
    (cont && $past(cont) && !$past(rst) && !dm_lock) |=> (host_dm_gnt != $past(host_dm_gnt)));

  p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cont && $past(cont) && !$past(rst) && dm_lock) |=> $stable(host_dm_gnt));

  p_drain_r5: assert property (@(posedge clk) disable iff (rst)
    (core_go && !run_req && !insn_done) |=> core_go);

  p_step_clear_r6: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_req);

  p_idle_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (tgt_gnt != 3'b000) |-> $past(core_idle));

  p_err_nogrant_r8: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (tgt_gnt == 3'b000));
endmodule

bind host_core_ctl hcc_chk u_chk (
  .clk(clk), .rst(rst), .core_go(core_go), .core_idle(core_idle),
  .run_req(run_req), .step_req(step_req), .step_done(step_done),
  .insn_done(core_insn_done), .host_dreq(host_dreq), .core_dreq(core_dreq),
  .dm_lock(dm_lock), .host_dm_gnt(host_dm_gnt), .core_dm_gnt(core_dm_gnt),
  .tgt_gnt(host_tgt_gnt), .acc_err(acc_err)
);

// File: tb/sim_host_core_ctl.sv
`timescale 1ns/1ps
module sim_host_core_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_cmd = 0, host_ae = 0, host_lockout = 0, host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic irq_line = 0, irq_ack;
  logic core_insn_done = 0, core_dreq = 0, dm_lock = 0;
  logic core_go, core_idle, cfg_fast_wr, cfg_latch_rd, cfg_latch_wr;
  logic [1:0] cfg_msel;
  logic host_dm_gnt, core_dm_gnt, acc_err;
  logic [3:1] host_tgt_gnt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  host_core_ctl u0 (
    .clk(clk), .rst(rst), .host_cmd(host_cmd), .host_ae(host_ae),
    .host_lockout(host_lockout), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_line(irq_line),
    .irq_ack(irq_ack), .core_insn_done(core_insn_done), .core_dreq(core_dreq),
    .dm_lock(dm_lock), .core_go(core_go), .core_idle(core_idle),
    .cfg_fast_wr(cfg_fast_wr), .cfg_latch_rd(cfg_latch_rd),
    .cfg_latch_wr(cfg_latch_wr), .cfg_msel(cfg_msel),
    .host_dm_gnt(host_dm_gnt), .core_dm_gnt(core_dm_gnt),
    .host_tgt_gnt(host_tgt_gnt), .acc_err(acc_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet;
    host_cmd = 0; host_ae = 0; host_rd = 0; host_wr = 0; host_lockout = 0;
  endtask

  task automatic reg_write(input logic [7:0] v);
    host_cmd = 1; host_ae = 1; host_wr = 1; host_wdata = v;
    tick();
    quiet();
  endtask

  task automatic reg_read(output logic [7:0] v);
    host_cmd = 1; host_ae = 1; host_rd = 1;
    tick();
    v = host_rdata;
    quiet();
  endtask

  task automatic mem_access(input logic rd);
    host_cmd = 0; host_ae = 1; host_rd = rd; host_wr = !rd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R3: reset state
    rst = 1; tick(); tick(); rst = 0;
    chk("R3 core_go", core_go, 0);
    chk("R3 core_idle", core_idle, 1);
    chk("R3 cfg", {cfg_fast_wr, cfg_latch_rd, cfg_latch_wr, cfg_msel}, 0);
    reg_read(rv);
    chk("R3 readback", rv, 0);

    // R1: sweep of the qualifier combinations on write and read
    for (int q = 0; q < 8; q++) begin
      bit ok;
      ok = (q[2] == 1) && (q[1] == 1) && (q[0] == 0);
      reg_write(8'h00);
      host_cmd = q[2]; host_ae = q[1]; host_lockout = q[0];
      host_wr = 1; host_wdata = 8'h38;
      tick(); quiet();
      chk("R1 write qual", {cfg_fast_wr, cfg_latch_rd, cfg_latch_wr}, ok ? 7 : 0);
      reg_write(8'h10);
      reg_read(rv);
      reg_write(8'h08);
      host_cmd = q[2]; host_ae = q[1]; host_lockout = q[0]; host_rd = 1;
      tick(); quiet();
      chk("R1 read qual", host_rdata, ok ? 8'h08 : 8'h10);
    end

    // R2: field layout sweep, readback with interrupt line both ways
    for (int v = 0; v < 32; v++) begin
      logic [7:0] w;
      w = {2'b00, v[4:2], 1'b0, v[1:0]};
      irq_line = v[0] ^ v[4];
      reg_write(w);
      chk("R2 outputs", {cfg_fast_wr, cfg_latch_rd, cfg_latch_wr, cfg_msel},
          {v[4:2], v[1:0]});
      reg_read(rv);
      chk("R2 readback", rv, {irq_line, w[6:0]});
    end
    irq_line = 0;
    reg_write(8'h80);
    chk("R2 irq_ack pulse", irq_ack, 1);
    tick();
    chk("R2 irq_ack clears", irq_ack, 0);

    // R4: start
    reg_write(8'h04);
    chk("R4 go after first edge", core_go, 0);
    tick();
    chk("R4 go after second edge", core_go, 1);
    chk("R4 not idle", core_idle, 0);

    // R8: denied targets while running
    for (int m = 1; m < 4; m++) begin
      reg_write(8'h04 | 8'(m));
      mem_access(m[0]);
      tick(); quiet();
      chk("R8 no grant", host_tgt_gnt, 0);
      chk("R8 err pulse", acc_err, 1);
      tick();
      chk("R8 err clears", acc_err, 0);
    end

    // R5: stop waits for instruction completion
    reg_write(8'h00);
    chk("R5 still going at write", core_go, 1);
    repeat (4) begin
      tick();
      chk("R5 draining", core_go, 1);
    end
    core_insn_done = 1; tick(); core_insn_done = 0;
    chk("R5 halted after done", core_go, 0);
    chk("R5 idle", core_idle, 1);
    reg_write(8'h04); tick();
    core_insn_done = 1;
    reg_write(8'h00);
    chk("R5 go at clear edge", core_go, 1);
    tick();
    chk("R5 halt next edge with done held", core_go, 0);
    core_insn_done = 0;

    // R7: granted targets while idle
    for (int m = 1; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        reg_write(8'(m));
        mem_access(r[0]);
        tick(); quiet();
        chk("R7 grant bit", host_tgt_gnt, 1 << (m - 1));
        chk("R7 no err", acc_err, 0);
        tick();
        chk("R7 grant one cycle", host_tgt_gnt, 0);
      end
    end

    // R6: single step
    reg_write(8'h40);
    chk("R6 not yet", core_go, 0);
    tick();
    chk("R6 stepping", core_go, 1);
    tick();
    chk("R6 waits for done", core_go, 1);
    core_insn_done = 1; tick(); core_insn_done = 0;
    chk("R6 halted", core_go, 0);
    reg_read(rv);
    chk("R6 step bit self clears", rv[6], 0);
    repeat (3) tick();
    chk("R6 only one instruction", core_go, 0);
    reg_write(8'h44);
    reg_read(rv);
    chk("R6 step with start ignored", rv[6], 0);
    reg_write(8'h40);
    reg_read(rv);
    chk("R6 step while running ignored", rv[6], 0);
    core_insn_done = 1; tick(); core_insn_done = 0;
    chk("R6 drained", core_idle, 1);

    // R9: data memory arbitration
    reg_write(8'h00);
    for (int i = 0; i < 4; i++) begin
      mem_access(1); core_dreq = 1;
      tick();
      chk("R9 contested host", host_dm_gnt, i % 2);
      chk("R9 contested core", core_dm_gnt, 1 - (i % 2));
    end
    quiet(); core_dreq = 0; tick();
    chk("R9 no request", {host_dm_gnt, core_dm_gnt}, 0);
    mem_access(0); tick(); quiet();
    chk("R9 host alone", {host_dm_gnt, core_dm_gnt}, 2'b10);
    core_dreq = 1; tick(); core_dreq = 0;
    chk("R9 core alone", {host_dm_gnt, core_dm_gnt}, 2'b01);
    mem_access(1); core_dreq = 1; tick();
    chk("R9 new run core first", {host_dm_gnt, core_dm_gnt}, 2'b01);
    quiet(); core_dreq = 0; tick();

    // R10: lock freezes the winner
    dm_lock = 1;
    for (int i = 0; i < 3; i++) begin
      mem_access(1); core_dreq = 1; tick();
      chk("R10 locked core", {host_dm_gnt, core_dm_gnt}, 2'b01);
    end
    quiet(); core_dreq = 0; dm_lock = 0; tick();
    mem_access(1); core_dreq = 1; tick();
    chk("R10 unlocked first", {host_dm_gnt, core_dm_gnt}, 2'b01);
    tick();
    chk("R10 unlocked second", {host_dm_gnt, core_dm_gnt}, 2'b10);
    dm_lock = 1;
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R10 locked host", {host_dm_gnt, core_dm_gnt}, 2'b10);
    end
    quiet(); core_dreq = 0; dm_lock = 0; tick();

    // R11: reset into running
    rst = 1; host_rd = 1; host_wr = 1; host_ae = 0; tick();
    rst = 0; quiet();
    chk("R11 running after reset", core_go, 1);
    reg_read(rv);
    chk("R11 start bit set", rv, 8'h04);
    rst = 1; host_rd = 1; host_wr = 1; host_ae = 1; tick();
    rst = 0; quiet();
    chk("R11 ae high stays stopped", core_go, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule